// File: doc/BRIEF.md
# Clock frequency select controller

This block settles the 5-bit frequency-select code that a clock generator's PLL and dividers act on. During a power-good window, signalled by an active-low strobe, it samples five select pins and a watchdog-enable pin. Once the window closes it keeps those values. A configuration byte then chooses who sets the frequency: the captured pins, or a code held in the same byte. The byte also turns spread spectrum on or off. The block classifies the active code as down-spread or center-spread.

A watchdog can be armed only when the enable pin was captured high. It counts clock cycles between kick pulses. When it runs out, it replaces the code with a safe code and raises a sticky flag. Another bit of the configuration byte chooses where that safe code comes from: the captured pins, or a second configuration field. The effective code passes through one output register. Each change of that code is marked by a single-cycle update strobe, so downstream logic can reprogram once per change. All pins here are plain control and status signals. The block has no streaming interface, so it has no valid/ready handshake.

Top module: `fsel_ctrl`

## Requirements
- R1: While `pg_strobe_n` is low, every rising clock edge captures `fs_pins` and `wd_en_pin`. While it is high, the captured values hold, and later pin changes have no effect on `code_out`.
- R2: When `cfg_b0[3]` is 0 and the watchdog has not fired, the effective code is the captured pin value, with `fs_pins[4]` as the most significant bit.
- R3: When `cfg_b0[3]` is 1 and the watchdog has not fired, the effective code is {`cfg_b0[2]`, `cfg_b0[7]`, `cfg_b0[6]`, `cfg_b0[5]`, `cfg_b0[4]`}, most significant bit first.
- R4: `spread_en` follows `cfg_b0[1]` one clock later: 1 enables spreading, 0 gives unspread operation.
- R5: `spread_center` is 0 (down-spread) when `code_out` is 0 to 3 and 1 (center-spread) for every other code. It is aligned with `code_out`.
- R6: The watchdog counts only if the captured watchdog-enable value is 1. Otherwise `wd_fired` never rises.
- R7: An armed watchdog clears its counter on every `wd_kick` edge. If there is no kick for `wd_term`+1 consecutive clock edges, `wd_fired` rises. `wd_fired` stays 1 until reset, whatever kicks follow.
- R8: After the watchdog fires, the effective code is the safe code, whatever `cfg_b0[3]` says. The safe code is the captured pins when `cfg_b0[0]` is 0, and `cfg_safe` when `cfg_b0[0]` is 1.
- R9: `code_out` takes the effective code one clock edge after it is formed. `code_upd` is 1 for exactly the cycle in which `code_out` takes a new value, and 0 otherwise.
- R10: Reset (`rst_n` low, asynchronous) clears the captured values, the watchdog state and all outputs to 0. The default source of the code after reset is the captured pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_pins | input | 5 | Hardware frequency-select pins |
| pg_strobe_n | input | 1 | Active-low power-good capture strobe |
| wd_en_pin | input | 1 | Watchdog enable pin, captured with the select pins |
| cfg_b0 | input | 8 | Control byte: code bits, source select, spread enable, safe-source select |
| cfg_safe | input | 5 | Programmed watchdog safe code |
| wd_term | input | WD_W | Watchdog terminal count |
| wd_kick | input | 1 | Watchdog reload pulse |
| code_out | output | 5 | Registered effective frequency code |
| code_upd | output | 1 | Single-cycle strobe marking a new code |
| spread_en | output | 1 | Spread-spectrum enable |
| spread_center | output | 1 | 1 = center-spread, 0 = down-spread |
| wd_fired | output | 1 | Sticky watchdog-expired flag |

## Verification
The hardest state to reach is an expiry that lands exactly on the terminal count while the register selection points elsewhere. Reaching it takes three things in order: a capture window with the enable pin high, a controlled stretch of kicks, and then a silence of a known length. A directed sequence re-arms the capture and kicks every third cycle. It then checks `wd_fired` one edge before and one edge after expiry, and switches the safe-source bit while the register code is selected. Random phases pulse reset and reopen the capture window now and then, with short terminal counts, so that expiries under random configuration happen often.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int CODE_W   = 5;
  localparam int DOWN_MAX = 3;

  typedef logic [CODE_W-1:0] fs_code_t;

  typedef enum logic {
    SPREAD_DOWN   = 1'b0,
    SPREAD_CENTER = 1'b1
  } spread_mode_e;

  // control byte field view, MSB first
  typedef struct packed {
    logic [3:0] fs_low;        // code bits 3..0
    logic       use_reg;       // 1: code from this byte
    logic       fs_top;        // code bit 4
    logic       spread_on;     // spread enable
    logic       safe_from_reg; // 1: safe code from programmed field
  } ctl_byte_t;

  function automatic spread_mode_e spread_mode_of(fs_code_t code);
    return (int'(code) > DOWN_MAX) ? SPREAD_CENTER : SPREAD_DOWN;
  endfunction
endpackage

// File: rtl/fsel_pin_latch.sv
module fsel_pin_latch import fsel_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     strobe_n,
  input  fs_code_t pins,
  input  logic     wd_en_pin,
  output fs_code_t lat_code,
  output logic     lat_wd_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_code  <= '0;
      lat_wd_en <= 1'b0;
    end else if (!strobe_n) begin
      lat_code  <= pins;
      lat_wd_en <= wd_en_pin;
    end
  end

  // R1
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |=> ($stable(lat_code) && $stable(lat_wd_en)));
endmodule

// File: rtl/fsel_watchdog.sv
module fsel_watchdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             kick,
  input  logic [CNT_W-1:0] term,
  output logic             fired
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_term;

  assign at_term = (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fired <= 1'b0;
    end else if (!enable || kick) begin
      cnt_q <= '0;
    end else if (!fired) begin
      if (at_term) fired <= 1'b1;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7
  fired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fired |=> fired);
  // R6
  fire_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired) |-> $past(enable));
  // R7
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0));
endmodule

// File: rtl/fsel_code_mux.sv
module fsel_code_mux import fsel_pkg::*; (
  input  fs_code_t     lat_code,
  input  logic [7:0]   ctl_raw,
  input  fs_code_t     safe_cfg,
  input  logic         fired,
  output fs_code_t     eff_code,
  output logic         spread_on,
  output spread_mode_e mode
);
  ctl_byte_t ctl;
  fs_code_t  run_code;
  fs_code_t  safe_code;

  always_comb begin
    ctl       = ctl_byte_t'(ctl_raw);
    run_code  = ctl.use_reg ? {ctl.fs_top, ctl.fs_low} : lat_code;
    safe_code = ctl.safe_from_reg ? safe_cfg : lat_code;
    eff_code  = fired ? safe_code : run_code;
    spread_on = ctl.spread_on;
    mode      = spread_mode_of(eff_code);
  end
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl import fsel_pkg::*; #(
  parameter int WD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        fs_pins,
  input  logic              pg_strobe_n,
  input  logic              wd_en_pin,
  input  logic [7:0]        cfg_b0,
  input  logic [4:0]        cfg_safe,
  input  logic [WD_W-1:0]   wd_term,
  input  logic              wd_kick,
  output logic [4:0]        code_out,
  output logic              code_upd,
  output logic              spread_en,
  output logic              spread_center,
  output logic              wd_fired
);
  fs_code_t     lat_code;
  logic         lat_wd_en;
  fs_code_t     eff_code;
  logic         spread_on;
  spread_mode_e mode;

  fsel_pin_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_n  (pg_strobe_n),
    .pins      (fs_pins),
    .wd_en_pin (wd_en_pin),
    .lat_code  (lat_code),
    .lat_wd_en (lat_wd_en)
  );

  fsel_watchdog #(.CNT_W(WD_W)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (lat_wd_en),
    .kick   (wd_kick),
    .term   (wd_term),
    .fired  (wd_fired)
  );

  fsel_code_mux u_mux (
    .lat_code  (lat_code),
    .ctl_raw   (cfg_b0),
    .safe_cfg  (cfg_safe),
    .fired     (wd_fired),
    .eff_code  (eff_code),
    .spread_on (spread_on),
    .mode      (mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_out      <= '0;
      code_upd      <= 1'b0;
      spread_en     <= 1'b0;
      spread_center <= 1'b0;
    end else begin
      code_out      <= eff_code;
      code_upd      <= (eff_code != code_out);
      spread_en     <= spread_on;
      spread_center <= (mode == SPREAD_CENTER);
    end
  end

  // R9
  upd_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_upd |-> (code_out != $past(code_out)));
  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_upd |-> $stable(code_out));
  // R5
  mode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spread_center == (code_out > 5'd3));
endmodule

// File: tb/sim_fsel_ctrl.sv
module sim_fsel_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  fs_pins = '0;
  logic        pg_strobe_n = 1'b1;
  logic        wd_en_pin = 1'b0;
  logic [7:0]  cfg_b0 = '0;
  logic [4:0]  cfg_safe = '0;
  logic [15:0] wd_term = 16'd5;
  logic        wd_kick = 1'b0;
  logic [4:0]  code_out;
  logic        code_upd, spread_en, spread_center, wd_fired;

  always #5 clk = ~clk;

  fsel_ctrl #(.WD_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .fs_pins(fs_pins), .pg_strobe_n(pg_strobe_n),
    .wd_en_pin(wd_en_pin), .cfg_b0(cfg_b0), .cfg_safe(cfg_safe),
    .wd_term(wd_term), .wd_kick(wd_kick), .code_out(code_out),
    .code_upd(code_upd), .spread_en(spread_en),
    .spread_center(spread_center), .wd_fired(wd_fired)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [4:0] f_eff(logic [4:0] lat, logic [7:0] b0,
                                       logic [4:0] sf, logic fired);
    logic [4:0] run_c, safe_c;
    run_c  = b0[3] ? {b0[2], b0[7:4]} : lat;
    safe_c = b0[0] ? sf : lat;
    return fired ? safe_c : run_c;
  endfunction

  // reference model built from the requirements
  logic [4:0]  m_lat, m_code;
  logic        m_wden, m_fired, m_upd, m_se, m_sc;
  logic [15:0] m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat <= '0; m_wden <= 1'b0; m_fired <= 1'b0; m_cnt <= '0;
      m_code <= '0; m_upd <= 1'b0; m_se <= 1'b0; m_sc <= 1'b0;
    end else begin
      logic [4:0] e;
      e = f_eff(m_lat, cfg_b0, cfg_safe, m_fired);
      m_code <= e;
      m_upd  <= (e != m_code);
      m_se   <= cfg_b0[1];
      m_sc   <= (e > 5'd3);
      if (!pg_strobe_n) begin
        m_lat  <= fs_pins;
        m_wden <= wd_en_pin;
      end
      if (!m_wden || wd_kick) m_cnt <= '0;
      else if (!m_fired) begin
        if (m_cnt == wd_term) m_fired <= 1'b1;
        else m_cnt <= m_cnt + 16'd1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R3", "code_out", code_out, m_code);
      chk("R9", "code_upd", code_upd, m_upd);
      chk("R4", "spread_en", spread_en, m_se);
      chk("R5", "spread_center", spread_center, m_sc);
      chk("R7", "wd_fired", wd_fired, m_fired);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch_pins(logic [4:0] p, logic en);
    fs_pins = p; wd_en_pin = en; pg_strobe_n = 1'b0;
    cyc(2);
    pg_strobe_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    // R10 reset state
    chk("R10", "code_out", code_out, 0);
    chk("R10", "code_upd", code_upd, 0);
    chk("R10", "spread_en", spread_en, 0);
    chk("R10", "wd_fired", wd_fired, 0);
    rst_n = 1'b1;
    cyc(2);
    latch_pins(5'h15, 1'b0);
    fs_pins = 5'h0B;
    cyc(3);
    chk("R2", "code from latched pins", code_out, 5'h15);
    chk("R1", "pins ignored after strobe", code_out, 5'h15);
    chk("R5", "center for 0x15", spread_center, 1);
    cyc(40);
    chk("R6", "disarmed watchdog silent", wd_fired, 0);

    latch_pins(5'h02, 1'b1);
    fs_pins = 5'h1F;
    for (int i = 0; i < 10; i++) begin
      wd_kick = 1'b1; cyc(1); wd_kick = 1'b0; cyc(2);
    end
    chk("R7", "kicked watchdog silent", wd_fired, 0);
    chk("R5", "down-spread for 0x02", spread_center, 0);
    cyc(3);
    chk("R7", "one edge before expiry", wd_fired, 0);
    cyc(1);
    chk("R7", "fires at term+1", wd_fired, 1);
    chk("R8", "safe from pins", code_out, 5'h02);
    cfg_safe = 5'h0A; cfg_b0 = 8'h01;
    cyc(2);
    chk("R8", "safe from cfg", code_out, 5'h0A);
    cfg_b0 = 8'h69;
    cyc(2);
    chk("R8", "register select overridden", code_out, 5'h0A);
    cfg_b0 = 8'h00;
    cyc(2);
    chk("R8", "safe back to pins", code_out, 5'h02);
    wd_kick = 1'b1; cyc(1); wd_kick = 1'b0; cyc(2);
    chk("R7", "fired sticky after kick", wd_fired, 1);

    rst_n = 1'b0; cyc(2); rst_n = 1'b1;
    cyc(2);
    chk("R10", "fired cleared by reset", wd_fired, 0);
    cfg_b0 = 8'h6C;
    cyc(1);
    chk("R3", "register code 0x16", code_out, 5'h16);
    chk("R9", "update strobe high", code_upd, 1);
    cyc(1);
    chk("R9", "update strobe one cycle", code_upd, 0);
    cfg_b0 = 8'h6E;
    cyc(1);
    chk("R4", "spread enabled", spread_en, 1);
    chk("R9", "no strobe without change", code_upd, 0);

    // random phase against the model
    rst_n = 1'b0; cyc(2); rst_n = 1'b1;
    cmp_on = 1'b1;
    for (int i = 0; i < 8000; i++) begin
      if (i % 600 == 599) begin
        rst_n = 1'b0;
        wd_term = 16'($urandom_range(1, 10));
        cyc(1);
        rst_n = 1'b1;
      end
      pg_strobe_n = ($urandom_range(0, 39) != 0);
      fs_pins     = 5'($urandom);
      wd_en_pin   = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 7) == 0) cfg_b0 = 8'($urandom);
      if ($urandom_range(0, 15) == 0) cfg_safe = 5'($urandom);
      wd_kick = ($urandom_range(0, 5) == 0);
      cyc(1);
    end
    cmp_on = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule